// File: doc/BRIEF.md
# Symmetric Int8 Block Quantizer

This block turns a fixed-length block of signed 16-bit fixed-point values into signed 8-bit codes and one per-block scale. The same block of values is streamed in twice over a valid/ready input. The first pass measures the magnitude of each value and keeps the largest one. That maximum is then published as the block scale, with a one-cycle valid pulse.

The second pass maps each value to `round(127 * value / scale)`. A bit-serial restoring divider does the division, one quotient bit per cycle. The codes leave through a valid/ready output stream in input order, and the last code of the block is flagged. There is no zero-point offset. Codes never take the value -128, so the code range is symmetric about zero.

A typical use is in a weight-loading path: a host-side sequencer replays each weight block through the quantizer and stores the codes together with the scale.

Top module: `symq8_quantizer`

## Requirements
- R1: After a synchronous reset, `in_ready` is 1, `code_valid` is 0 and `scale_valid` is 0.
- R2: The first `BLOCK_LEN` accepted values form pass one. After the last of them, `scale_valid` is high for exactly one cycle, and `scale_data` then equals the largest magnitude in the block. This pulse comes before the first code of the block.
- R3: For a nonzero scale, each code equals `round(127*|v|/scale)` with the sign of `v` applied. Exact halves round away from zero, so 0.5 gives 1 and -2.5 gives -3.
- R4: Every code lies in -127..+127, and the two's-complement value 0x80 (-128) is never emitted.
- R5: An input of -32768 is given magnitude 32767. With a scale of 32767 it yields the code -127.
- R6: When the scale is 0, every code of the block is 0.
- R7: While a division is in progress, `in_ready` is 0. It is therefore low on the cycle that follows a pass-two value being accepted under a nonzero scale.
- R8: Codes leave in input order. `code_last` is 1 on the `BLOCK_LEN`-th code and 0 on the others. Once that code has been taken, the block starts pass one of the next block.
- R9: While `code_valid` is 1 and `code_ready` is 0, `code_valid`, `code_data` and `code_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input value valid |
| in_ready | output | 1 | Block accepts an input value |
| in_data | input | DATA_W | Signed input value |
| scale_valid | output | 1 | One-cycle pulse: scale_data holds the block scale |
| scale_data | output | DATA_W-1 | Largest magnitude of the block |
| code_valid | output | 1 | Output code valid |
| code_ready | input | 1 | Consumer takes the code |
| code_data | output | CODE_W | Signed symmetric code |
| code_last | output | 1 | Marks the final code of a block |

## Verification
The bench builds the block with `BLOCK_LEN = 8` and the default 16-bit data and 8-bit codes. Eight-value blocks can be written out by hand, so one block can hold an exact rounding tie of either sign, the most negative input, the full-scale positive value and zeros, and each code can be predicted exactly. The short block also makes it cheap to run many back-to-back blocks with random output back-pressure. That in turn exercises the hand-off from the drain of one block into pass one of the next.

// File: rtl/symq8_pkg.sv
`timescale 1ns/1ps
package symq8_pkg;
  // Sequencing of one block: measure, publish scale, divide, drain last code
  typedef enum logic [1:0] {
    ST_SCAN  = 2'd0,
    ST_SCALE = 2'd1,
    ST_QUANT = 2'd2,
    ST_DRAIN = 2'd3
  } symq8_state_e;
endpackage

// File: rtl/symq8_magscan.sv
`timescale 1ns/1ps
module symq8_magscan #(
  parameter int DATA_W = 16,
  localparam int MAG_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample,
  input  logic              restart,
  input  logic [DATA_W-1:0] value,
  output logic [MAG_W-1:0]  mag,
  output logic [MAG_W-1:0]  run_max
);
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] neg_val;
  logic [MAG_W-1:0]  base;

  // Magnitude, with the most negative code clamped to the top positive one
  always_comb begin
    neg_val = -value;
    if (value == MOST_NEG)
      mag = {MAG_W{1'b1}};
    else if (value[DATA_W-1])
      mag = neg_val[MAG_W-1:0];
    else
      mag = value[MAG_W-1:0];
  end

  assign base = restart ? '0 : run_max;

  always_ff @(posedge clk) begin
    if (rst)
      run_max <= '0;
    else if (sample)
      run_max <= (mag > base) ? mag : base;
  end
endmodule

// File: rtl/symq8_divider.sv
`timescale 1ns/1ps
module symq8_divider #(
  parameter int NUM_W = 23,
  parameter int DEN_W = 16,
  localparam int CNT_W = $clog2(NUM_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quot
);
  logic [DEN_W-1:0] rem;
  logic [DEN_W-1:0] den_q;
  logic [NUM_W-1:0] dvd;
  logic [CNT_W-1:0] cnt;
  logic [DEN_W:0]   rem_sh;
  logic [DEN_W+1:0] diff;
  logic             borrow;

  // One restoring step: shift in a dividend bit, try to subtract
  always_comb begin
    rem_sh = {rem, dvd[NUM_W-1]};
    diff   = {1'b0, rem_sh} - {2'b00, den_q};
    borrow = diff[DEN_W+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem   <= '0;
      den_q <= '0;
      dvd   <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem   <= '0;
        den_q <= den;
        dvd   <= num;
        cnt   <= CNT_W'(NUM_W);
        busy  <= 1'b1;
      end else if (busy) begin
        rem <= borrow ? rem_sh[DEN_W-1:0] : diff[DEN_W-1:0];
        dvd <= {dvd[NUM_W-2:0], ~borrow};
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quot = dvd;
endmodule

// File: rtl/symq8_outreg.sv
`timescale 1ns/1ps
module symq8_outreg #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] load_data,
  input  logic              load_last,
  input  logic              ready,
  output logic              valid,
  output logic [CODE_W-1:0] data,
  output logic              last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
      last  <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
      last  <= load_last;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/symq8_quantizer.sv
`timescale 1ns/1ps
module symq8_quantizer #(
  parameter int DATA_W    = 16,
  parameter int CODE_W    = 8,
  parameter int BLOCK_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              scale_valid,
  output logic [DATA_W-2:0] scale_data,
  output logic              code_valid,
  input  logic              code_ready,
  output logic [CODE_W-1:0] code_data,
  output logic              code_last
);
  import symq8_pkg::*;

  localparam int MAG_W = DATA_W - 1;
  localparam int QMAX  = (1 << (CODE_W - 1)) - 1;
  localparam int NUM_W = MAG_W + CODE_W;   // (2*QMAX+1)*max fits here
  localparam int DEN_W = MAG_W + 1;
  localparam int CNT_W = $clog2(BLOCK_LEN + 1);

  symq8_state_e      state;
  logic [CNT_W-1:0]  cnt;
  logic              acc;
  logic              cnt_end;
  logic [MAG_W-1:0]  in_mag;
  logic [MAG_W-1:0]  run_max;
  logic [MAG_W-1:0]  scale_q;
  logic              div_start;
  logic              div_busy;
  logic              div_done;
  logic [NUM_W-1:0]  div_quot;
  logic [NUM_W-1:0]  num_w;
  logic [DEN_W-1:0]  den_w;
  logic              neg_q;
  logic              last_q;
  logic [CODE_W-1:0] qclamp;
  logic [CODE_W-1:0] div_code;
  logic              zero_load;
  logic              out_load;
  logic [CODE_W-1:0] out_data;
  logic              out_last;

  assign cnt_end = (cnt == CNT_W'(BLOCK_LEN - 1));

  always_comb begin
    case (state)
      ST_SCAN:  in_ready = 1'b1;
      ST_QUANT: in_ready = !div_busy && !div_done && (!code_valid || code_ready);
      default:  in_ready = 1'b0;
    endcase
  end

  assign acc = in_valid && in_ready;

  symq8_magscan #(.DATA_W(DATA_W)) u_scan (
    .clk     (clk),
    .rst     (rst),
    .sample  (acc && (state == ST_SCAN)),
    .restart (cnt == '0),
    .value   (in_data),
    .mag     (in_mag),
    .run_max (run_max)
  );

  // round(QMAX*m/s) = floor((2*QMAX*m + s) / (2*s)), ties away from zero
  assign num_w = NUM_W'(in_mag) * NUM_W'(2 * QMAX) + NUM_W'(scale_q);
  assign den_w = {scale_q, 1'b0};

  assign div_start = acc && (state == ST_QUANT) && (scale_q != '0);
  assign zero_load = acc && (state == ST_QUANT) && (scale_q == '0);

  symq8_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (div_start),
    .num   (num_w),
    .den   (den_w),
    .busy  (div_busy),
    .done  (div_done),
    .quot  (div_quot)
  );

  always_comb begin
    qclamp   = (div_quot > NUM_W'(QMAX)) ? CODE_W'(QMAX) : div_quot[CODE_W-1:0];
    div_code = neg_q ? -qclamp : qclamp;
  end

  assign out_load = div_done || zero_load;
  assign out_data = div_done ? div_code : '0;
  assign out_last = div_done ? last_q : cnt_end;

  symq8_outreg #(.CODE_W(CODE_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (out_load),
    .load_data (out_data),
    .load_last (out_last),
    .ready     (code_ready),
    .valid     (code_valid),
    .data      (code_data),
    .last      (code_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_SCAN;
      cnt         <= '0;
      scale_q     <= '0;
      scale_valid <= 1'b0;
      neg_q       <= 1'b0;
      last_q      <= 1'b0;
    end else begin
      scale_valid <= 1'b0;
      if (div_start) begin
        neg_q  <= in_data[DATA_W-1];
        last_q <= cnt_end;
      end
      case (state)
        ST_SCAN: if (acc) begin
          cnt <= cnt_end ? '0 : cnt + 1'b1;
          if (cnt_end) state <= ST_SCALE;
        end
        ST_SCALE: begin
          scale_q     <= run_max;
          scale_valid <= 1'b1;
          state       <= ST_QUANT;
        end
        ST_QUANT: if (acc) begin
          cnt <= cnt_end ? '0 : cnt + 1'b1;
          if (cnt_end) state <= ST_DRAIN;
        end
        default: if (code_valid && code_ready && code_last) state <= ST_SCAN;
      endcase
    end
  end

  assign scale_data = scale_q;
endmodule

// File: rtl/symq8_checker.sv
`timescale 1ns/1ps
module symq8_checker #(
  parameter int CODE_W = 8,
  parameter int MAG_W  = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              scale_valid,
  input logic [MAG_W-1:0]  scale_q,
  input logic              code_valid,
  input logic              code_ready,
  input logic [CODE_W-1:0] code_data,
  input logic              code_last,
  input logic              div_busy
);
  localparam logic [CODE_W-1:0] MIN_CODE = {1'b1, {(CODE_W-1){1'b0}}};

  a_r4_no_min_code: assert property (@(posedge clk) disable iff (rst)
    code_valid |-> code_data != MIN_CODE);

  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (code_valid && !code_ready) |=> (code_valid && $stable(code_data) && $stable(code_last)));

  a_r2_scale_one_cycle: assert property (@(posedge clk) disable iff (rst)
    scale_valid |=> !scale_valid);

  a_r2_scale_before_code: assert property (@(posedge clk) disable iff (rst)
    scale_valid |-> !code_valid);

  a_r7_busy_blocks_input: assert property (@(posedge clk) disable iff (rst)
    div_busy |-> !in_ready);

  a_r6_zero_scale_code: assert property (@(posedge clk) disable iff (rst)
    (code_valid && scale_q == '0) |-> code_data == '0);
endmodule

bind symq8_quantizer symq8_checker #(.CODE_W(CODE_W), .MAG_W(MAG_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_ready    (in_ready),
  .scale_valid (scale_valid),
  .scale_q     (scale_q),
  .code_valid  (code_valid),
  .code_ready  (code_ready),
  .code_data   (code_data),
  .code_last   (code_last),
  .div_busy    (div_busy)
);

// File: tb/sim_symq8_quantizer.sv
`timescale 1ns/1ps
module sim_symq8_quantizer;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        scale_valid;
  logic [14:0] scale_data;
  logic        code_valid;
  logic        code_ready = 1'b1;
  logic [7:0]  code_data;
  logic        code_last;

  int total = 0;
  int bad = 0;
  int scale_cnt = 0;
  int scale_val = 0;
  int blk [N];

  always #5 clk = ~clk;

  symq8_quantizer #(.DATA_W(16), .CODE_W(8), .BLOCK_LEN(N)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .scale_valid(scale_valid), .scale_data(scale_data),
    .code_valid(code_valid), .code_ready(code_ready),
    .code_data(code_data), .code_last(code_last)
  );

  always @(negedge clk) begin
    if (!rst && scale_valid) begin
      scale_cnt++;
      scale_val = int'(scale_data);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int mag_of(input int v);
    if (v == -32768) return 32767;
    return (v < 0) ? -v : v;
  endfunction

  function automatic int exp_code(input int v, input int m);
    int q;
    if (m == 0) return 0;
    q = (254 * mag_of(v) + m) / (2 * m);
    if (q > 127) q = 127;
    return (v < 0) ? -q : q;
  endfunction

  // Streams blk[] twice, collects N codes; stall != 0 applies random back-pressure
  task automatic run_block(input string name, input int stall);
    int m = 0;
    for (int i = 0; i < N; i++) if (mag_of(blk[i]) > m) m = mag_of(blk[i]);
    scale_cnt = 0;
    fork
      begin
        for (int i = 0; i < 2 * N; i++) begin
          @(negedge clk);
          in_valid = 1'b1;
          in_data  = 16'(blk[i % N]);
          #1;
          while (!in_ready) begin
            @(negedge clk);
            #1;
          end
          @(posedge clk);
          if (i >= N && m != 0) begin
            @(negedge clk);
            #1;
            chk(!in_ready, "R7 in_ready during divide", int'(in_ready), 0);
          end
        end
        @(negedge clk);
        in_valid = 1'b0;
      end
      begin
        int k = 0;
        bit was_stalled = 0;
        logic [7:0] held = '0;
        while (k < N) begin
          @(negedge clk);
          code_ready = (stall != 0) ? (($urandom % 3) != 0) : 1'b1;
          #1;
          if (was_stalled)
            chk(code_valid && code_data == held, "R9 hold under stall", int'(code_data), int'(held));
          was_stalled = code_valid && !code_ready;
          held = code_data;
          if (code_valid && code_ready) begin
            if (k == 0) chk(scale_cnt == 1, "R2 scale before first code", scale_cnt, 1);
            chk(int'($signed(code_data)) == exp_code(blk[k], m),
                $sformatf("R3 %s code %0d", name, k), int'($signed(code_data)), exp_code(blk[k], m));
            chk(code_data != 8'h80, "R4 no -128", int'($signed(code_data)), -127);
            chk(code_last == (k == N - 1), "R8 last flag", int'(code_last), int'(k == N - 1));
            k++;
          end
        end
        @(negedge clk);
        code_ready = 1'b1;
      end
    join
    chk(scale_cnt == 1, $sformatf("R2 %s scale pulse count", name), scale_cnt, 1);
    chk(scale_val == m, $sformatf("R2 %s scale value", name), scale_val, m);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    chk(code_valid == 1'b0, "R1 code_valid after reset", int'(code_valid), 0);
    chk(scale_valid == 1'b0, "R1 scale_valid after reset", int'(scale_valid), 0);
  endtask

  task automatic t_ramp();   // R3 general values
    blk = '{100, -200, 300, -400, 500, -1000, 50, 0};
    run_block("ramp", 0);
  endtask

  task automatic t_ties();   // R3 exact halves of both signs
    blk = '{1, -1, 3, -3, 254, 0, -5, 127};
    run_block("ties", 0);
  endtask

  task automatic t_extreme(); // R4 and R5: most negative input, full scale
    blk = '{-32768, 32767, -32767, 1, -1, 16384, -16384, 0};
    run_block("extreme", 0);
  endtask

  task automatic t_minonly(); // R5: -32768 alone sets the scale
    blk = '{16384, -32768, 2, -3, 0, 100, -100, 8000};
    run_block("minonly", 0);
  endtask

  task automatic t_zero();    // R6: zero block
    blk = '{0, 0, 0, 0, 0, 0, 0, 0};
    run_block("zero", 0);
  endtask

  task automatic t_stall();   // R9 and R7 under back-pressure
    blk = '{-7, 13, -1999, 2000, 4, -4, 999, -1001};
    run_block("stall", 1);
  endtask

  task automatic t_b2b();     // R8: blocks back to back
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < N; i++) blk[i] = (i * 37 * (b + 1)) - 150;
      run_block($sformatf("b2b%0d", b), b % 2);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ramp();
    t_ties();
    t_extreme();
    t_minonly();
    t_zero();
    t_stall();
    t_b2b();
    repeat (5) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule